// File: doc/BRIEF.md
# Multiply-Augmented Quarter-Round Mixer

This block mixes four 64-bit words through a chain of four add-XOR-rotate steps. Each addition is augmented: besides the two operands, it also adds twice the unsigned product of their low 32-bit halves. This makes each step non-linear over integer addition as well as over XOR. The chain has strict order. Every step reads the words that the steps before it have already updated.

The datapath is purely combinational. A parameter `REGISTERED` selects whether one output register stage with a valid flag follows the chain. When the stage is present, the register captures a result only in a cycle where `valid_in` is high. The result and `valid_out` appear one clock later. When the stage is absent, the outputs follow the inputs in the same cycle and `valid_out` equals `valid_in`. A larger permutation that schedules words into the block sits outside it.

The datapath has no states. The only sequential element is the optional output register, which has two conditions: IDLE (`valid_out` low) and HOLDING (`valid_out` high, results stable). A cycle with `valid_in` high moves the register to HOLDING and loads it. A cycle with `valid_in` low moves it to IDLE and leaves the data unchanged. Reset forces IDLE with all data at zero.

Top module: `mix_quarter_round`

## Requirements
- R1: The augmented add of x and y is x + y + (P << 1) modulo 2^64. P is the unsigned product of x[31:0] and y[31:0], kept to 64 bits, and the shift drops bit 63. For example, 3 and 5 give 38. Two operands of 0x00000000FFFFFFFF give 0xFFFFFFFE00000000.
- R2: Step 1 sets a to the augmented add of a and b. It then sets d to (d XOR a) rotated left by 32.
- R3: Step 2 sets c to the augmented add of c and d. It then sets b to (b XOR c) rotated left by 40.
- R4: Step 3 sets a to the augmented add of a and b. It then sets d to (d XOR a) rotated left by 48.
- R5: Step 4 sets c to the augmented add of c and d. It then sets b to (b XOR c) rotated left by 1. The four outputs are the words after step 4, and each step uses the results of all earlier steps.
- R6: With REGISTERED=1, `valid_out` in each cycle equals `valid_in` of the previous cycle. The outputs then carry the result for the inputs present in that previous cycle.
- R7: With REGISTERED=1, a cycle with `valid_in` low leaves `a_out`..`d_out` unchanged, whatever the data inputs do.
- R8: With REGISTERED=1, while `rst_n` is low, `valid_out` and all four outputs are zero.
- R9: With REGISTERED=0, the outputs equal the mixed words of the present inputs in the same cycle, and `valid_out` equals `valid_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Input words are valid this cycle |
| a_in | input | 64 | Word a |
| b_in | input | 64 | Word b |
| c_in | input | 64 | Word c |
| d_in | input | 64 | Word d |
| valid_out | output | 1 | Output words are valid |
| a_out | output | 64 | Mixed word a |
| b_out | output | 64 | Mixed word b |
| c_out | output | 64 | Mixed word c |
| d_out | output | 64 | Mixed word d |

## Verification
On every clock edge, the assertions check the following:
- The XOR-rotate steps of R2 and R5 invert back to their inputs.
- Every augmented sum differs from the plain sum by an even amount.
- The valid flag has a delay of exactly one cycle.
- The outputs hold while `valid_in` is low.

Only the scenarios in the bench can show that the full values match the ordered four-step chain. They also check the exact products at the edge of the 32-bit range, the zero state during reset, and that the combinational variant is transparent.

// File: rtl/mix_pkg.sv
package mix_pkg;
    localparam int WORD_W = 64;
    localparam int HALF_W = WORD_W / 2;
    typedef logic [WORD_W-1:0] word_t;

    // Rotation amounts of the four steps, in step order.
    localparam int ROT_S1 = 32;
    localparam int ROT_S2 = 40;
    localparam int ROT_S3 = 48;
    localparam int ROT_S4 = 1;

    // Inverse rotation, used only by the checks.
    function automatic word_t rotr(input word_t x, input int r);
        return (x >> r) | (x << (WORD_W - r));
    endfunction
endpackage

// File: rtl/mix_aug_add.sv
module mix_aug_add
    import mix_pkg::*;
#(
    parameter int W = WORD_W,
    localparam int H = W / 2
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    logic [W-1:0] prod;
    logic [W-1:0] x_lo;
    logic [W-1:0] y_lo;

    assign x_lo = {{(W-H){1'b0}}, x[H-1:0]};
    assign y_lo = {{(W-H){1'b0}}, y[H-1:0]};
    assign prod = x_lo * y_lo;
    assign sum  = x + y + {prod[W-2:0], 1'b0};
endmodule

// File: rtl/mix_xor_rotl.sv
module mix_xor_rotl #(
    parameter int W   = 64,
    parameter int ROT = 1
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    output logic [W-1:0] r
);
    logic [W-1:0] x;
    assign x = p ^ q;
    // Fixed wiring: rotate left by ROT.
    assign r = {x[W-1-ROT:0], x[W-1:W-ROT]};
endmodule

// File: rtl/mix_step.sv
module mix_step
    import mix_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int ROT = 1
) (
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] add_in,
    input  logic [W-1:0] mix_in,
    output logic [W-1:0] acc_out,
    output logic [W-1:0] mix_out
);
    mix_aug_add #(.W(W)) u_add (
        .x   (acc_in),
        .y   (add_in),
        .sum (acc_out)
    );

    mix_xor_rotl #(.W(W), .ROT(ROT)) u_rot (
        .p (mix_in),
        .q (acc_out),
        .r (mix_out)
    );
endmodule

// File: rtl/mix_quarter_round.sv
module mix_quarter_round
    import mix_pkg::*;
#(
    parameter int W          = WORD_W,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_in,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] c_in,
    input  logic [W-1:0] d_in,
    output logic         valid_out,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic [W-1:0] c_out,
    output logic [W-1:0] d_out
);
    logic [W-1:0] a1, d1, c1, b1, a2, d2, c2, b2;

    mix_step #(.W(W), .ROT(ROT_S1)) u_s1 (
        .acc_in(a_in), .add_in(b_in), .mix_in(d_in), .acc_out(a1), .mix_out(d1));
    mix_step #(.W(W), .ROT(ROT_S2)) u_s2 (
        .acc_in(c_in), .add_in(d1),   .mix_in(b_in), .acc_out(c1), .mix_out(b1));
    mix_step #(.W(W), .ROT(ROT_S3)) u_s3 (
        .acc_in(a1),   .add_in(b1),   .mix_in(d1),   .acc_out(a2), .mix_out(d2));
    mix_step #(.W(W), .ROT(ROT_S4)) u_s4 (
        .acc_in(c1),   .add_in(d2),   .mix_in(b1),   .acc_out(c2), .mix_out(b2));

    generate
        if (REGISTERED) begin : g_reg
            logic         v_q;
            logic [W-1:0] a_q, b_q, c_q, d_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    a_q <= '0;
                    b_q <= '0;
                    c_q <= '0;
                    d_q <= '0;
                end else begin
                    v_q <= valid_in;
                    if (valid_in) begin
                        a_q <= a2;
                        b_q <= b2;
                        c_q <= c2;
                        d_q <= d2;
                    end
                end
            end

            assign valid_out = v_q;
            assign a_out     = a_q;
            assign b_out     = b_q;
            assign c_out     = c_q;
            assign d_out     = d_q;

            p_valid_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
                valid_in |=> valid_out);
            p_valid_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_in |=> !valid_out);
            p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_in |=> ($stable(a_out) && $stable(b_out) && $stable(c_out) && $stable(d_out)));
        end else begin : g_comb
            assign valid_out = valid_in;
            assign a_out     = a2;
            assign b_out     = b2;
            assign c_out     = c2;
            assign d_out     = d2;
        end
    endgenerate

    // The doubled product is even, so each augmented sum has the parity of the plain sum.
    p_even_aug_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((a1 - a_in - b_in) & W'(1)) == '0);
    // Undoing the step 1 rotate and XOR gives back the incoming d.
    p_step1_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rotr(d1, ROT_S1) ^ a1) == d_in);
    // Undoing the step 4 rotate and XOR gives back the b from step 2.
    p_step4_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rotr(b2, ROT_S4) ^ c2) == b1);
endmodule

// File: tb/tb_mix_quarter_round.sv
module tb_mix_quarter_round;
    typedef logic [63:0] w_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_in = 1'b0;
    w_t a_in = '0, b_in = '0, c_in = '0, d_in = '0;
    logic valid_out, valid_c;
    w_t a_out, b_out, c_out, d_out;
    w_t a_c, b_c, c_c, d_c;
    w_t ax = '0, ay = '0, asum;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mix_quarter_round #(.REGISTERED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
        .valid_out(valid_out), .a_out(a_out), .b_out(b_out), .c_out(c_out), .d_out(d_out));

    mix_quarter_round #(.REGISTERED(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
        .valid_out(valid_c), .a_out(a_c), .b_out(b_c), .c_out(c_c), .d_out(d_c));

    mix_aug_add #(.W(64)) dut_add (.x(ax), .y(ay), .sum(asum));

    // Reference model, written from the requirements.
    function automatic w_t ref_aug(input w_t x, input w_t y);
        w_t p;
        p = {32'h0, x[31:0]} * {32'h0, y[31:0]};
        return x + y + (p << 1);
    endfunction

    function automatic w_t ref_rotl(input w_t x, input int r);
        return (x << r) | (x >> (64 - r));
    endfunction

    function automatic logic [255:0] ref_mix(input w_t a, input w_t b, input w_t c, input w_t d);
        a = ref_aug(a, b); d = ref_rotl(d ^ a, 32);
        c = ref_aug(c, d); b = ref_rotl(b ^ c, 40);
        a = ref_aug(a, b); d = ref_rotl(d ^ a, 48);
        c = ref_aug(c, d); b = ref_rotl(b ^ c, 1);
        return {a, b, c, d};
    endfunction

    localparam int NV = 8;
    localparam w_t VEC [NV][4] = '{
        '{64'h0, 64'h0, 64'h0, 64'h0},
        '{64'h3, 64'h5, 64'h0, 64'h0},
        '{64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h2},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F0F_0F0F_0F0F_0F0F, 64'hF0F0_F0F0_F0F0_F0F0},
        '{64'h8000_0000_0000_0000, 64'h1, 64'h8000_0000_8000_0000, 64'h7FFF_FFFF_7FFF_FFFF},
        '{64'hDEAD_BEEF_CAFE_F00D, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h1},
        '{64'h5555_5555_AAAA_AAAA, 64'hAAAA_AAAA_5555_5555, 64'h3333_3333_CCCC_CCCC, 64'hCCCC_CCCC_3333_3333}
    };

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [255:0] exp, last;
        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 reset data", {a_out, b_out, c_out, d_out}, '0);
        check("R8 reset valid", {255'h0, valid_out}, '0);
        rst_n = 1'b1;

        // R1: augmented add corner values
        ax = 64'h3; ay = 64'h5; #1;
        check("R1 3+5", asum, 64'd38);
        ax = 64'h0000_0000_FFFF_FFFF; ay = 64'h0000_0000_FFFF_FFFF; #1;
        check("R1 max halves", asum, 64'hFFFF_FFFE_0000_0000);
        ax = 64'hFFFF_FFFF_0000_0000; ay = 64'h1234; #1;
        check("R1 zero low half", asum, 64'hFFFF_FFFF_0000_1234);

        // R2..R5, R6, R9: vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a_in = VEC[i][0]; b_in = VEC[i][1]; c_in = VEC[i][2]; d_in = VEC[i][3];
            valid_in = 1'b1;
            exp = ref_mix(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
            #1;
            check("R9 comb", {a_c, b_c, c_c, d_c}, exp);
            check("R9 comb valid", {255'h0, valid_c}, 256'h1);
            @(negedge clk);
            valid_in = 1'b0;
            check("R2 R3 R4 R5 mix", {a_out, b_out, c_out, d_out}, exp);
            check("R6 valid", {255'h0, valid_out}, 256'h1);
        end

        // R7: hold while valid_in low
        last = {a_out, b_out, c_out, d_out};
        @(negedge clk);
        a_in = 64'h1111; b_in = 64'h2222; c_in = 64'h3333; d_in = 64'h4444;
        check("R6 valid drop", {255'h0, valid_out}, '0);
        repeat (2) @(negedge clk);
        check("R7 hold", {a_out, b_out, c_out, d_out}, last);
        check("R9 comb idle valid", {255'h0, valid_c}, '0);

        // R6: back-to-back captures
        @(negedge clk);
        valid_in = 1'b1;
        a_in = VEC[4][1]; b_in = VEC[4][0]; c_in = VEC[4][3]; d_in = VEC[4][2];
        @(negedge clk);
        check("R6 b2b first", {a_out, b_out, c_out, d_out}, ref_mix(VEC[4][1], VEC[4][0], VEC[4][3], VEC[4][2]));
        a_in = 64'h7; b_in = 64'h9; c_in = 64'hB; d_in = 64'hD;
        @(negedge clk);
        valid_in = 1'b0;
        check("R6 b2b second", {a_out, b_out, c_out, d_out}, ref_mix(64'h7, 64'h9, 64'hB, 64'hD));

        // R8: reset again clears held data
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 async clear", {a_out, b_out, c_out, d_out, 255'h0, valid_out} == '0 ? 256'h0 : 256'h1, '0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule